// File: doc/BRIEF.md
# Three-Lane TMDS Pixel Encoder with Register Access

This block turns packed colour words into 10-bit TMDS symbols for three video lanes. Software loads a 32-bit colour word and a control word, then issues reads. A read either only inspects the encoding (peek) or also consumes it (pop). Consuming a pixel commits the running DC balance of the lanes involved and shifts the colour word so that the next pixel moves into the low bits.

Each lane takes its 8-bit colour value from the low 16 bits of the colour word. Each lane applies its own right rotation and its own count of valid most-significant bits. The lane then runs the usual two-stage TMDS encode: a transition-minimising XOR/XNOR chain, then a conditional inversion steered by that lane's running disparity. A single-pixel read returns all three lane symbols in one word, either packed by lane or interleaved in 2-bit pieces. A double-pixel read returns two successive symbols of one lane.

Top module: `tmds_pixel_encoder`

## Requirements
- R1: Control bits 3:0, 7:4 and 11:8 hold the rotation for lanes 0, 1 and 2. A lane right-rotates the low 16 bits of the colour word by that amount, and its colour value is bits 7:0 of the result.
- R2: Control bits 14:12, 17:15 and 20:18 hold the bit count for lanes 0, 1 and 2. A value n keeps the top n+1 bits of the lane's 8-bit colour value and forces the other bits to zero.
- R3: Stage one uses XNOR when the colour value has more than four ones, or exactly four ones with bit 0 clear, and XOR otherwise. Symbol bit 8 is 1 for XOR. Stage two inverts bits 7:0 and sets bit 9 according to the standard disparity rules. Each lane keeps its own running count, which is zero after reset.
- R4: With rd_mode 0 (single), rd_data holds lane 0 in bits 9:0, lane 1 in bits 19:10 and lane 2 in bits 29:20, and bits 31:30 are zero.
- R5: When control bit 23 is set, a single read is interleaved instead. Output bits 2k+1:2k, for k from 0 to 14, carry bits 2(k/3)+1:2(k/3) of lane k mod 3. Bits 31:30 are zero.
- R6: rd_mode 1, 2 and 3 select a double read of lane 0, 1 and 2. The first pixel's symbol is in bits 9:0 and the second in bits 19:10, and bits 31:20 are zero. The second pixel comes from the colour word shifted right by the shift amount, or from the unshifted word when control bit 27 is set. Its disparity follows on from the first symbol's.
- R7: A peek (rd_pop low) changes neither the colour word nor any running count.
- R8: A single pop shifts the colour word right, filling with zeros. Control bits 26:24 give the distance: code 0 to 5 means 0, 1, 2, 4, 8 or 16 bits, and codes 6 and 7 mean no shift. All three lanes' counts advance by one symbol.
- R9: A double pop shifts the colour word by twice the shift amount, or by the shift amount once when bit 27 is set. Only the selected lane's count advances, through both symbols in order.
- R10: A control write with bit 28 set zeroes all running counts at that edge, even when a pop happens in the same cycle. The bit is not kept, so later pops advance normally.
- R11: A colour word write in the same cycle as a pop takes priority over the shift, while the pop still advances the counts. After reset the control word and the colour word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write value |
| data_we | input | 1 | Colour word write strobe |
| data_wdata | input | 32 | Colour word write value |
| rd_en | input | 1 | Read access in this cycle |
| rd_pop | input | 1 | Read consumes the pixel (1) or only inspects it (0) |
| rd_mode | input | 2 | 0 single pixel, 1 to 3 double read of lane 0 to 2 |
| rd_data | output | 32 | Encoded read result for the current state |

## Verification
Long pop runs over varied 8-bit colour values drive each lane's disparity through positive, negative and zero states. This separates the stage-two inversion branches and the XOR/XNOR choice, including the tie at four ones. Sweeps of rotation and bit count with a fixed colour word show which bits each lane selects and masks. Double reads, with and without bit 27, show whether the second pixel is taken from the right data and whether the disparity is chained. Each shift code is followed by a peek, which shows the new colour word through the encoded output.

// File: rtl/tmds_enc_pkg.sv
package tmds_enc_pkg;
  localparam int LANES  = 3;
  localparam int SYM_W  = 10;
  localparam int COL_W  = 8;
  localparam int ACC_W  = 16;
  localparam int WORD_W = 32;
  localparam int ROT_W  = 4;
  localparam int NB_W   = 3;
  localparam int DISP_W = 6;

  typedef enum logic [1:0] {
    RD_SINGLE = 2'd0,
    RD_DBL_L0 = 2'd1,
    RD_DBL_L1 = 2'd2,
    RD_DBL_L2 = 2'd3
  } rd_mode_e;

  typedef struct packed {
    logic [2:0]                  shift_code;
    logic                        keep_second;
    logic                        interleave;
    logic [LANES-1:0][NB_W-1:0]  nbits;
    logic [LANES-1:0][ROT_W-1:0] rot;
  } ctrl_t;

  function automatic logic [5:0] shift_distance(input logic [2:0] code);
    case (code)
      3'd1:    shift_distance = 6'd1;
      3'd2:    shift_distance = 6'd2;
      3'd3:    shift_distance = 6'd4;
      3'd4:    shift_distance = 6'd8;
      3'd5:    shift_distance = 6'd16;
      default: shift_distance = 6'd0;
    endcase
  endfunction
endpackage

// File: rtl/tmds_color_extract.sv
module tmds_color_extract #(
  parameter int ACC_W = 16,
  parameter int COL_W = 8,
  parameter int ROT_W = 4,
  parameter int NB_W  = 3
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [ROT_W-1:0] rot,
  input  logic [NB_W-1:0]  nbits,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] raw;
  logic [COL_W-1:0] keep_mask;

  always_comb begin
    raw       = COL_W'({acc, acc} >> rot);
    keep_mask = ~({COL_W{1'b1}} >> ({1'b0, nbits} + 1'b1));
    col       = raw & keep_mask;
  end
endmodule

// File: rtl/tmds_symbol_enc.sv
module tmds_symbol_enc #(
  parameter int DISP_W = 6
) (
  input  logic [7:0]               d,
  input  logic signed [DISP_W-1:0] disp_in,
  output logic [9:0]               sym,
  output logic signed [DISP_W-1:0] disp_out
);
  localparam logic signed [DISP_W-1:0] TWO   = DISP_W'(2);
  localparam logic signed [DISP_W-1:0] EIGHT = DISP_W'(8);

  logic [3:0]               ones_d;
  logic                     use_xnor;
  logic [8:0]               qm;
  logic signed [DISP_W-1:0] ones_q;
  logic signed [DISP_W-1:0] diff;

  always_comb begin
    ones_d = '0;
    for (int i = 0; i < 8; i++) ones_d = ones_d + 4'(d[i]);
    use_xnor = (ones_d > 4'd4) || ((ones_d == 4'd4) && !d[0]);
    qm[0] = d[0];
    for (int i = 1; i < 8; i++)
      qm[i] = use_xnor ? ~(qm[i-1] ^ d[i]) : (qm[i-1] ^ d[i]);
    qm[8] = ~use_xnor;
    ones_q = '0;
    for (int i = 0; i < 8; i++) ones_q = ones_q + DISP_W'(qm[i]);
    diff = (ones_q <<< 1) - EIGHT;   // ones minus zeros

    if ((disp_in == 0) || (diff == 0)) begin
      sym      = {~qm[8], qm[8], qm[8] ? qm[7:0] : ~qm[7:0]};
      disp_out = qm[8] ? (disp_in + diff) : (disp_in - diff);
    end else if (((disp_in > 0) && (diff > 0)) || ((disp_in < 0) && (diff < 0))) begin
      sym      = {1'b1, qm[8], ~qm[7:0]};
      disp_out = disp_in + (qm[8] ? TWO : '0) - diff;
    end else begin
      sym      = {1'b0, qm[8], qm[7:0]};
      disp_out = disp_in - (qm[8] ? '0 : TWO) + diff;
    end
  end
endmodule

// File: rtl/tmds_lane.sv
module tmds_lane #(
  parameter int ACC_W  = 16,
  parameter int COL_W  = 8,
  parameter int ROT_W  = 4,
  parameter int NB_W   = 3,
  parameter int SYM_W  = 10,
  parameter int DISP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] acc_a,
  input  logic [ACC_W-1:0] acc_b,
  input  logic [ROT_W-1:0] rot,
  input  logic [NB_W-1:0]  nbits,
  input  logic             clr,
  input  logic             adv_one,
  input  logic             adv_two,
  output logic [SYM_W-1:0] sym_a,
  output logic [SYM_W-1:0] sym_b
);
  logic [COL_W-1:0]         col_a, col_b;
  logic signed [DISP_W-1:0] disp_q, disp_d, disp_mid, disp_end;
  logic                     disp_en;

  tmds_color_extract #(.ACC_W(ACC_W), .COL_W(COL_W), .ROT_W(ROT_W), .NB_W(NB_W)) u_ext_a (
    .acc(acc_a), .rot(rot), .nbits(nbits), .col(col_a));
  tmds_color_extract #(.ACC_W(ACC_W), .COL_W(COL_W), .ROT_W(ROT_W), .NB_W(NB_W)) u_ext_b (
    .acc(acc_b), .rot(rot), .nbits(nbits), .col(col_b));

  tmds_symbol_enc #(.DISP_W(DISP_W)) u_enc_a (
    .d(col_a), .disp_in(disp_q), .sym(sym_a), .disp_out(disp_mid));
  tmds_symbol_enc #(.DISP_W(DISP_W)) u_enc_b (
    .d(col_b), .disp_in(disp_mid), .sym(sym_b), .disp_out(disp_end));

  always_comb begin
    disp_en = clr || adv_one || adv_two;
    if (clr)          disp_d = '0;
    else if (adv_two) disp_d = disp_end;
    else              disp_d = disp_mid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       disp_q <= '0;
    else if (disp_en) disp_q <= disp_d;
  end

  AST_CLEAR_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (disp_q == 0)); // R10
  AST_BALANCE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !adv_one && !adv_two) |=> $stable(disp_q)); // R7
  AST_DISP_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    disp_q[0] == 1'b0); // R3
endmodule

// File: rtl/tmds_pixel_encoder.sv
module tmds_pixel_encoder
  import tmds_enc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [WORD_W-1:0] ctrl_wdata,
  input  logic              data_we,
  input  logic [WORD_W-1:0] data_wdata,
  input  logic              rd_en,
  input  logic              rd_pop,
  input  logic [1:0]        rd_mode,
  output logic [WORD_W-1:0] rd_data
);
  localparam int CHUNKS  = LANES * SYM_W / 2;
  localparam int NB_BASE = LANES * ROT_W;
  localparam int IL_BIT  = 23;
  localparam int SC_BIT  = 24;
  localparam int KS_BIT  = 27;
  localparam int CLR_BIT = 28;

  logic [1:0]        rst_sync;
  logic              rst_sync_n;
  ctrl_t             ctrl_q, ctrl_d;
  logic [WORD_W-1:0] data_q, data_d;
  logic              data_en;
  rd_mode_e          mode;
  logic              pop;
  logic              clr;
  logic [5:0]        shamt, pop_sh;
  logic [ACC_W-1:0]  acc_b;
  logic [SYM_W-1:0]  sym_a [LANES];
  logic [SYM_W-1:0]  sym_b [LANES];
  logic              unused_ctrl;

  assign unused_ctrl = ^{ctrl_wdata[WORD_W-1:CLR_BIT+1], ctrl_wdata[IL_BIT-1:NB_BASE+LANES*NB_W]};

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  always_comb begin
    mode   = rd_mode_e'(rd_mode);
    pop    = rd_en && rd_pop;
    clr    = ctrl_we && ctrl_wdata[CLR_BIT];
    shamt  = shift_distance(ctrl_q.shift_code);
    pop_sh = ((mode != RD_SINGLE) && !ctrl_q.keep_second) ? (shamt << 1) : shamt;
    acc_b  = ctrl_q.keep_second ? data_q[ACC_W-1:0] : ACC_W'(data_q >> shamt);

    ctrl_d.shift_code  = ctrl_wdata[SC_BIT +: 3];
    ctrl_d.keep_second = ctrl_wdata[KS_BIT];
    ctrl_d.interleave  = ctrl_wdata[IL_BIT];
    for (int l = 0; l < LANES; l++) begin
      ctrl_d.rot[l]   = ctrl_wdata[l*ROT_W +: ROT_W];
      ctrl_d.nbits[l] = ctrl_wdata[NB_BASE + l*NB_W +: NB_W];
    end

    data_en = data_we || pop;
    data_d  = data_we ? data_wdata : (data_q >> pop_sh);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q <= '0;
      data_q <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_d;
      if (data_en) data_q <= data_d;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tmds_lane #(.ACC_W(ACC_W), .COL_W(COL_W), .ROT_W(ROT_W), .NB_W(NB_W),
                .SYM_W(SYM_W), .DISP_W(DISP_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .acc_a   (data_q[ACC_W-1:0]),
      .acc_b   (acc_b),
      .rot     (ctrl_q.rot[g]),
      .nbits   (ctrl_q.nbits[g]),
      .clr     (clr),
      .adv_one (pop && (mode == RD_SINGLE)),
      .adv_two (pop && (rd_mode == 2'(g + 1))),
      .sym_a   (sym_a[g]),
      .sym_b   (sym_b[g])
    );
  end

  always_comb begin
    rd_data = '0;
    case (mode)
      RD_SINGLE: begin
        if (ctrl_q.interleave) begin
          for (int k = 0; k < CHUNKS; k++)
            rd_data[2*k +: 2] = sym_a[k % LANES][2*(k / LANES) +: 2];
        end else begin
          for (int l = 0; l < LANES; l++)
            rd_data[l*SYM_W +: SYM_W] = sym_a[l];
        end
      end
      RD_DBL_L0: rd_data[2*SYM_W-1:0] = {sym_b[0], sym_a[0]};
      RD_DBL_L1: rd_data[2*SYM_W-1:0] = {sym_b[1], sym_a[1]};
      RD_DBL_L2: rd_data[2*SYM_W-1:0] = {sym_b[2], sym_a[2]};
      default:   rd_data = '0;
    endcase
  end

  AST_PEEK_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && !rd_pop && !data_we) |=> $stable(data_q)); // R7
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    data_we |=> (data_q == $past(data_wdata))); // R11
  AST_SINGLE_PAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_mode == 2'd0) |-> (rd_data[WORD_W-1:LANES*SYM_W] == '0)); // R4
  AST_DOUBLE_PAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_mode != 2'd0) |-> (rd_data[WORD_W-1:2*SYM_W] == '0)); // R6
endmodule

// File: tb/tmds_pixel_encoder_bench.sv
module tmds_pixel_encoder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctrl_we, data_we, rd_en, rd_pop;
  logic [31:0] ctrl_wdata, data_wdata;
  logic [1:0]  rd_mode;
  logic [31:0] rd_data;

  int          checks = 0;
  int          errors = 0;
  logic [31:0] m_data, m_ctrl;
  int          m_disp [3];
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  tmds_pixel_encoder u_tmds_pixel_encoder (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .data_we(data_we), .data_wdata(data_wdata), .rd_en(rd_en), .rd_pop(rd_pop),
    .rd_mode(rd_mode), .rd_data(rd_data));

  function automatic logic [31:0] next_rand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic int shift_of(input logic [2:0] c);
    case (c)
      3'd1: return 1;  3'd2: return 2;  3'd3: return 4;
      3'd4: return 8;  3'd5: return 16; default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] lane_val(input logic [31:0] w, input int l);
    logic [31:0] t;
    logic [7:0]  mask;
    int          nb;
    t    = {w[15:0], w[15:0]} >> m_ctrl[4*l +: 4];
    nb   = int'(m_ctrl[12 + 3*l +: 3]);
    mask = 8'hFF << (7 - nb);
    return t[7:0] & mask;
  endfunction

  function automatic logic [9:0] ref_enc(input logic [7:0] d, input int disp, output int disp_o);
    int n1, a, b, q8;
    bit xn;
    logic [8:0] qm;
    logic [9:0] q;
    n1 = 0;
    for (int i = 0; i < 8; i++) n1 += int'(d[i]);
    xn = (n1 > 4) || (n1 == 4 && d[0] == 1'b0);
    qm[0] = d[0];
    for (int i = 1; i < 8; i++) qm[i] = xn ? ~(qm[i-1] ^ d[i]) : (qm[i-1] ^ d[i]);
    qm[8] = !xn;
    q8 = int'(qm[8]);
    a = 0;
    for (int i = 0; i < 8; i++) a += int'(qm[i]);
    b = 8 - a;
    if (disp == 0 || a == b) begin
      q = {~qm[8], qm[8], qm[8] ? qm[7:0] : ~qm[7:0]};
      disp_o = qm[8] ? disp + a - b : disp + b - a;
    end else if ((disp > 0 && a > b) || (disp < 0 && b > a)) begin
      q = {1'b1, qm[8], ~qm[7:0]};
      disp_o = disp + 2*q8 + b - a;
    end else begin
      q = {1'b0, qm[8], qm[7:0]};
      disp_o = disp - 2*(1 - q8) + a - b;
    end
    return q;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: rd_data=%08h expected %08h", req, act, exp_v);
    end
  endtask

  task automatic do_read(input int mode, input bit pop, input string req);
    logic [9:0]  sa [3];
    logic [9:0]  sb [3];
    int          nd [3];
    int          mid;
    int          l;
    logic [31:0] exp_w, src_b;
    for (int i = 0; i < 3; i++) begin nd[i] = m_disp[i]; sa[i] = '0; sb[i] = '0; end
    exp_w = '0;
    mid = 0;
    if (mode == 0) begin
      for (int i = 0; i < 3; i++) sa[i] = ref_enc(lane_val(m_data, i), m_disp[i], nd[i]);
      if (m_ctrl[23]) begin
        for (int k = 0; k < 15; k++) exp_w[2*k +: 2] = sa[k % 3][2*(k / 3) +: 2];
      end else begin
        exp_w = {2'b00, sa[2], sa[1], sa[0]};
      end
    end else begin
      l = mode - 1;
      src_b = m_ctrl[27] ? m_data : (m_data >> shift_of(m_ctrl[26:24]));
      sa[l] = ref_enc(lane_val(m_data, l), m_disp[l], mid);
      sb[l] = ref_enc(lane_val(src_b, l), mid, nd[l]);
      exp_w = {12'h000, sb[l], sa[l]};
    end
    @(negedge clk);
    rd_en = 1'b1; rd_pop = pop; rd_mode = 2'(mode);
    #1;
    check(req, rd_data, exp_w);
    @(posedge clk); #1;
    rd_en = 1'b0; rd_pop = 1'b0;
    if (pop) begin
      m_disp = nd;
      if (mode != 0 && !m_ctrl[27]) m_data = m_data >> (2 * shift_of(m_ctrl[26:24]));
      else                          m_data = m_data >> shift_of(m_ctrl[26:24]);
    end
  endtask

  task automatic wr_ctrl(input logic [31:0] w);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = w;
    @(posedge clk); #1;
    ctrl_we = 1'b0;
    m_ctrl = w & ~(32'h1 << 28);
    if (w[28]) for (int i = 0; i < 3; i++) m_disp[i] = 0;
  endtask

  task automatic wr_data(input logic [31:0] w);
    @(negedge clk);
    data_we = 1'b1; data_wdata = w;
    @(posedge clk); #1;
    data_we = 1'b0;
    m_data = w;
  endtask

  task automatic t_reset;
    // R11: zero words after reset; R3/R4: value 0 encodes to 0x100 on every lane
    @(negedge clk);
    rd_en = 1'b1; rd_pop = 1'b0; rd_mode = 2'd0;
    #1;
    check("R11 reset", rd_data, 32'h1004_0100);
    @(posedge clk); #1; rd_en = 1'b0;
  endtask

  task automatic t_extract;
    wr_data(32'hFFFF_A5C3);
    for (int r = 0; r < 16; r += 3) begin
      for (int n = 0; n < 8; n += 3) begin
        wr_ctrl(32'(r) | (32'((r + 5) % 16) << 4) | (32'((r + 9) % 16) << 8)
                | (32'(n) << 12) | (32'(7 - n) << 15) | (32'((n + 2) % 8) << 18));
        do_read(0, 1'b0, "R1 R2 rotate/mask");
      end
    end
  endtask

  task automatic t_balance;
    wr_ctrl(32'h0000_0000 | (32'd0) | (32'd4 << 4) | (32'd8 << 8) | (32'h1FF << 12));
    for (int i = 0; i < 30; i++) begin
      wr_data(next_rand());
      do_read(0, 1'b0, "R7 peek before pop");
      do_read(0, 1'b1, "R3 running balance");
    end
    do_read(0, 1'b0, "R7 peek after pops");
  endtask

  task automatic t_interleave;
    wr_ctrl((32'd2 << 4) | (32'd12 << 8) | (32'h1FF << 12) | (32'h1 << 23));
    for (int i = 0; i < 4; i++) begin
      wr_data(next_rand());
      do_read(0, 1'b1, "R5 interleave");
    end
  endtask

  task automatic t_double;
    for (int ks = 0; ks < 2; ks++) begin
      wr_ctrl((32'd4 << 24) | (32'(ks) << 27) | (32'd3 << 4) | (32'h1FF << 12));
      for (int l = 1; l < 4; l++) begin
        wr_data(next_rand());
        do_read(l, 1'b0, "R6 double peek");
        do_read(l, 1'b1, "R9 double pop");
        do_read(0, 1'b0, "R9 data and other lanes after double pop");
      end
    end
  endtask

  task automatic t_shift;
    for (int c = 0; c < 8; c++) begin
      wr_ctrl((32'(c) << 24) | (32'd4 << 4) | (32'd8 << 8) | (32'h1FF << 12));
      wr_data(32'h9C3A_65E1);
      do_read(0, 1'b1, "R8 pop");
      do_read(0, 1'b0, "R8 shifted word");
    end
  endtask

  task automatic t_clear;
    int nd;
    // R10: clear alone
    wr_ctrl(m_ctrl | (32'h1 << 28));
    do_read(0, 1'b0, "R10 cleared");
    do_read(0, 1'b1, "R10 pop after clear");
    // R10: clear and pop together, clear wins on the counts
    wr_data(32'h00F0_3C5A);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = m_ctrl | (32'h1 << 28) | (32'd1 << 24);
    rd_en = 1'b1; rd_pop = 1'b1; rd_mode = 2'd0;
    @(posedge clk); #1;
    ctrl_we = 1'b0; rd_en = 1'b0; rd_pop = 1'b0;
    m_data = m_data >> shift_of(m_ctrl[26:24]);
    m_ctrl = ctrl_wdata & ~(32'h1 << 28);
    for (int i = 0; i < 3; i++) m_disp[i] = 0;
    nd = 0;
    do_read(0, 1'b0, "R10 clear beats pop");
    do_read(0, 1'b1, "R10 not retained");
    do_read(0, 1'b0, "R10 counts advance again");
  endtask

  task automatic t_write_wins;
    int nd [3];
    for (int i = 0; i < 3; i++) void'(ref_enc(lane_val(m_data, i), m_disp[i], nd[i]));
    @(negedge clk);
    data_we = 1'b1; data_wdata = 32'h0000_B7E4;
    rd_en = 1'b1; rd_pop = 1'b1; rd_mode = 2'd0;
    @(posedge clk); #1;
    data_we = 1'b0; rd_en = 1'b0; rd_pop = 1'b0;
    m_data = 32'h0000_B7E4;
    m_disp = nd;
    do_read(0, 1'b0, "R11 write beats pop shift");
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ctrl_we = 1'b0; data_we = 1'b0; rd_en = 1'b0; rd_pop = 1'b0;
    ctrl_wdata = '0; data_wdata = '0; rd_mode = 2'd0;
    m_data = '0; m_ctrl = '0;
    for (int i = 0; i < 3; i++) m_disp[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_extract();
    t_balance();
    t_interleave();
    t_double();
    t_shift();
    t_clear();
    t_write_wins();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule